// File: doc/BRIEF.md
# CCD Pixel Region Tagger

This block follows the serial sample stream of a full-frame CCD readout chain. It keeps a line counter and a column counter, driven by a pixel-valid strobe and by start-of-frame and start-of-line markers from the timing generator. Every sample leaves the block one cycle later with a region code attached. The region code tells later stages whether the sample came from an extra shift phase (dummy), a light-shielded pixel (dark), the untested unshielded border band (buffer), the tested image area (active), or a read past the end of a line or frame (overclock).

For buffer and active samples the block also reports the colour-filter site. On each line it sums the shielded leading dark-reference samples and emits one scaled dark-reference value per line. The scaling is a plain right shift, so the result is an approximate average. A line that is cut short by an early start-of-line marker raises a one-cycle error pulse.

The column layout across a line is, in order: dummy columns, dark-reference columns, leading buffer, active, trailing buffer, and then shielded trailing columns. The line layout down a frame is, in order: top dark lines, buffer lines, active lines, buffer lines, and then dark lines to the end of the frame. All sizes are parameters.

Top module: `ccd_region_tagger`

## Requirements
- R1: While reset is held and in the first cycle after it, `tag_vld_o`, `dark_avg_vld_o` and `line_err_o` are low. Samples that arrive before the first `sof_i` are tagged overclock (code 4).
- R2: Region codes are 0 dummy, 1 dark, 2 buffer, 3 active and 4 overclock. On every line inside the frame, columns 0 to DUMMY_COLS-1 are tagged dummy.
- R3: On lines that are not fully dark, the DARK_COLS columns that follow the dummy columns are tagged dark. So are all columns after the trailing buffer band, up to the end of the line.
- R4: The first TOP_DARK lines of a frame are tagged dark in every non-dummy column. So is every line from the end of the lower buffer band up to FRAME_LINES-1, a band of at least BOT_DARK lines.
- R5: The effective window starts at line TOP_DARK and at the first column after the dark-reference band. A BUF_BAND-wide band of buffer lines and columns surrounds an ACTIVE_COLS by ACTIVE_ROWS area. Samples in the band are tagged buffer and samples in the area are tagged active.
- R6: A sample on line FRAME_LINES or later, or at column LINE_LEN or later within a line, is tagged overclock.
- R7: The colour code is 0 R, 1 Gr, 2 Gb, 3 B. It is non-zero only for buffer or active samples. The first BLUE_LEAD leading buffer columns give 3. Every other buffer or active sample gives the code {line parity, column parity}. Line parity is counted from line TOP_DARK, and column parity is counted from the first column after the blue columns.
- R8: `dark_avg_o` is the sum of a line's dark-reference samples shifted right by AVG_SHIFT. `dark_avg_vld_o` pulses once per line, together with the tag of the last dark-reference sample. Samples from dummy, buffer and active columns never enter the sum.
- R9: `line_err_o` pulses high for one cycle, in the cycle after `sol_i`, when the line being closed lies inside the frame and had fewer than LINE_LEN samples. Otherwise it stays low.
- R10: `sof_i` restarts at line 0, column 0 at any time. `sol_i` advances the line and returns the column to 0.
- R11: `tag_vld_o`, `region_o`, `cfa_o` and `pix_data_o` follow a valid input sample by exactly one cycle. The data is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe |
| sol_i | input | 1 | Start-of-line strobe |
| pix_vld_i | input | 1 | Sample valid |
| pix_data_i | input | DW | Sample value |
| tag_vld_o | output | 1 | Tagged sample valid |
| region_o | output | 3 | Region code |
| cfa_o | output | 2 | Colour-filter site |
| pix_data_o | output | DW | Sample value, delayed |
| dark_avg_o | output | DW+clog2(DARK_COLS+1)-AVG_SHIFT | Scaled dark-reference sum |
| dark_avg_vld_o | output | 1 | Dark-reference value valid |
| line_err_o | output | 1 | Short-line error pulse |

## Verification
The assertions assume that a marker (`sof_i` or `sol_i`) and a valid sample never fall in the same cycle. They also assume that the dark-reference columns arrive without a line break in the middle. The single-pulse and dark-tag checks on the average rely on both of these. The bench keeps to these rules by issuing each marker on its own cycle with the valid strobe low, and by leaving an idle cycle after every sample. It still covers short lines, lines that run past their length, lines past the end of the frame, and a frame restart in the middle of a line.

// File: rtl/ccdtag_pkg.sv
package ccdtag_pkg;
   typedef enum logic [2:0] {
      RG_DUMMY   = 3'd0,
      RG_DARK    = 3'd1,
      RG_BUFFER  = 3'd2,
      RG_ACTIVE  = 3'd3,
      RG_OVERCLK = 3'd4
   } region_t;

   localparam logic [1:0] CFA_R  = 2'd0;
   localparam logic [1:0] CFA_GR = 2'd1;
   localparam logic [1:0] CFA_GB = 2'd2;
   localparam logic [1:0] CFA_B  = 2'd3;
endpackage

// File: rtl/ccdtag_counters.sv
module ccdtag_counters #(
   parameter int LINE_LEN    = 4641,
   parameter int FRAME_LINES = 3695,
   parameter int LW          = 12,
   parameter int CW          = 13
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sof_i,
   input  logic          sol_i,
   input  logic          pix_vld_i,
   output logic [LW-1:0] line_o,
   output logic [CW-1:0] col_o,
   output logic          line_err_o
);
   localparam logic [LW-1:0] LINES_C = LW'(FRAME_LINES);
   localparam logic [CW-1:0] LEN_C   = CW'(LINE_LEN);

   // Out of reset the line counter parks past the frame, so stray samples read as overclock.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         line_o     <= LINES_C;
         col_o      <= '0;
         line_err_o <= 1'b0;
      end else begin
         line_err_o <= 1'b0;
         if (sof_i) begin
            line_o <= '0;
            col_o  <= '0;
         end else if (sol_i) begin
            line_err_o <= (line_o < LINES_C) && (col_o < LEN_C);
            if (line_o < LINES_C) line_o <= line_o + 1'b1;
            col_o <= '0;
         end else if (pix_vld_i && (col_o < LEN_C)) begin
            col_o <= col_o + 1'b1;
         end
      end
   end

   a_r11_marker_not_with_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pix_vld_i && (sof_i || sol_i)));
   a_r6_col_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_o <= LEN_C);
   a_r10_sof_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sof_i |=> (line_o == '0) && (col_o == '0));
   a_r9_err_follows_sol: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_err_o |-> $past(sol_i));
endmodule

// File: rtl/ccdtag_classify.sv
module ccdtag_classify
   import ccdtag_pkg::*;
#(
   parameter int LINE_LEN    = 4641,
   parameter int FRAME_LINES = 3695,
   parameter int DUMMY_COLS  = 20,
   parameter int DARK_COLS   = 36,
   parameter int BUF_BAND    = 20,
   parameter int BLUE_LEAD   = 4,
   parameter int ACTIVE_COLS = 4500,
   parameter int ACTIVE_ROWS = 3600,
   parameter int TOP_DARK    = 30,
   parameter int BOT_DARK    = 23,
   parameter bit COLOR       = 1'b1,
   parameter int LW          = 12,
   parameter int CW          = 13
) (
   input  logic [LW-1:0] line_i,
   input  logic [CW-1:0] col_i,
   output region_t       region_o,
   output logic [1:0]    cfa_o
);
   localparam int BUF0_I    = DUMMY_COLS + DARK_COLS;
   localparam int ACT0_I    = BUF0_I + BUF_BAND;
   localparam int ACTEND_I  = ACT0_I + ACTIVE_COLS;
   localparam int BUFEND_I  = ACTEND_I + BUF_BAND;
   localparam int BAYER0_I  = BUF0_I + BLUE_LEAD;
   localparam int RACT0_I   = TOP_DARK + BUF_BAND;
   localparam int RACTEND_I = RACT0_I + ACTIVE_ROWS;
   localparam int REFEND_I  = RACTEND_I + BUF_BAND;

   localparam logic [CW-1:0] C_LEN    = CW'(LINE_LEN);
   localparam logic [CW-1:0] C_DARK0  = CW'(DUMMY_COLS);
   localparam logic [CW-1:0] C_BUF0   = CW'(BUF0_I);
   localparam logic [CW-1:0] C_ACT0   = CW'(ACT0_I);
   localparam logic [CW-1:0] C_ACTEND = CW'(ACTEND_I);
   localparam logic [CW-1:0] C_BUFEND = CW'(BUFEND_I);
   localparam logic [CW-1:0] C_BAYER0 = CW'(BAYER0_I);
   localparam logic [LW-1:0] L_FRAME  = LW'(FRAME_LINES);
   localparam logic [LW-1:0] L_EFF0   = LW'(TOP_DARK);
   localparam logic [LW-1:0] L_ACT0   = LW'(RACT0_I);
   localparam logic [LW-1:0] L_ACTEND = LW'(RACTEND_I);
   localparam logic [LW-1:0] L_EFFEND = LW'(REFEND_I);
   localparam logic R_PAR = 1'(TOP_DARK % 2);
   localparam logic C_PAR = 1'(BAYER0_I % 2);

   if (BUFEND_I > LINE_LEN) begin : g_bad_line_layout
      $error("column bands exceed LINE_LEN");
   end
   if (REFEND_I + BOT_DARK > FRAME_LINES) begin : g_bad_frame_layout
      $error("line bands exceed FRAME_LINES");
   end
   if (BLUE_LEAD > BUF_BAND) begin : g_bad_blue_lead
      $error("BLUE_LEAD wider than the buffer band");
   end

   logic eff_row, act_row;

   always_comb begin
      eff_row = (line_i >= L_EFF0) && (line_i < L_EFFEND);
      act_row = (line_i >= L_ACT0) && (line_i < L_ACTEND);
      if ((line_i >= L_FRAME) || (col_i >= C_LEN)) region_o = RG_OVERCLK;
      else if (col_i < C_DARK0)                    region_o = RG_DUMMY;
      else if (!eff_row)                           region_o = RG_DARK;
      else if (col_i < C_BUF0)                     region_o = RG_DARK;
      else if (col_i < C_ACT0)                     region_o = RG_BUFFER;
      else if (col_i < C_ACTEND)                   region_o = act_row ? RG_ACTIVE : RG_BUFFER;
      else if (col_i < C_BUFEND)                   region_o = RG_BUFFER;
      else                                         region_o = RG_DARK;
   end

   if (COLOR) begin : g_color
      always_comb begin
         cfa_o = CFA_R;
         if ((region_o == RG_BUFFER) || (region_o == RG_ACTIVE)) begin
            if (col_i < C_BAYER0) cfa_o = CFA_B;
            else                  cfa_o = {line_i[0] ^ R_PAR, col_i[0] ^ C_PAR};
         end
      end
   end else begin : g_mono
      assign cfa_o = CFA_R;
   end
endmodule

// File: rtl/ccdtag_darkacc.sv
module ccdtag_darkacc #(
   parameter int DW         = 16,
   parameter int DUMMY_COLS = 20,
   parameter int DARK_COLS  = 36,
   parameter int AVG_SHIFT  = 5,
   parameter int CW         = 13,
   parameter int ACC_W      = DW + $clog2(DARK_COLS + 1),
   parameter int AVG_W      = ACC_W - AVG_SHIFT
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             pix_vld_i,
   input  logic             line_ok_i,
   input  logic [CW-1:0]    col_i,
   input  logic [DW-1:0]    data_i,
   output logic [AVG_W-1:0] avg_o,
   output logic             avg_vld_o
);
   localparam logic [CW-1:0] C_FIRST = CW'(DUMMY_COLS);
   localparam logic [CW-1:0] C_LAST  = CW'(DUMMY_COLS + DARK_COLS - 1);

   if (AVG_SHIFT >= ACC_W || DARK_COLS < 1) begin : g_bad_acc
      $error("accumulator parameters out of range");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic             take;

   assign take = pix_vld_i && line_ok_i && (col_i >= C_FIRST) && (col_i <= C_LAST);
   assign sum  = acc_q + ACC_W'(data_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q     <= '0;
         avg_o     <= '0;
         avg_vld_o <= 1'b0;
      end else begin
         avg_vld_o <= 1'b0;
         if (clr_i) begin
            acc_q <= '0;
         end else if (take) begin
            if (col_i == C_LAST) begin
               acc_q     <= '0;
               avg_o     <= sum[ACC_W-1:AVG_SHIFT];
               avg_vld_o <= 1'b1;
            end else begin
               acc_q <= sum;
            end
         end
      end
   end

   a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      avg_vld_o |=> !avg_vld_o);
endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
   import ccdtag_pkg::*;
#(
   parameter int DW          = 16,
   parameter int LINE_LEN    = 4641,
   parameter int FRAME_LINES = 3695,
   parameter int DUMMY_COLS  = 20,
   parameter int DARK_COLS   = 36,
   parameter int BUF_BAND    = 20,
   parameter int BLUE_LEAD   = 4,
   parameter int ACTIVE_COLS = 4500,
   parameter int ACTIVE_ROWS = 3600,
   parameter int TOP_DARK    = 30,
   parameter int BOT_DARK    = 23,
   parameter int AVG_SHIFT   = 5,
   parameter bit COLOR       = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sof_i,
   input  logic          sol_i,
   input  logic          pix_vld_i,
   input  logic [DW-1:0] pix_data_i,
   output logic          tag_vld_o,
   output logic [2:0]    region_o,
   output logic [1:0]    cfa_o,
   output logic [DW-1:0] pix_data_o,
   output logic [DW+$clog2(DARK_COLS+1)-AVG_SHIFT-1:0] dark_avg_o,
   output logic          dark_avg_vld_o,
   output logic          line_err_o
);
   localparam int LW    = $clog2(FRAME_LINES + 1);
   localparam int CW    = $clog2(LINE_LEN + 1);
   localparam int ACC_W = DW + $clog2(DARK_COLS + 1);
   localparam int AVG_W = ACC_W - AVG_SHIFT;
   localparam logic [LW-1:0] L_FRAME = LW'(FRAME_LINES);

   logic [LW-1:0] line_q;
   logic [CW-1:0] col_q;
   region_t       rg;
   logic [1:0]    cf;
   logic          line_ok;

   ccdtag_counters #(
      .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .LW(LW), .CW(CW)
   ) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .sol_i(sol_i),
      .pix_vld_i(pix_vld_i), .line_o(line_q), .col_o(col_q),
      .line_err_o(line_err_o)
   );

   ccdtag_classify #(
      .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .DUMMY_COLS(DUMMY_COLS),
      .DARK_COLS(DARK_COLS), .BUF_BAND(BUF_BAND), .BLUE_LEAD(BLUE_LEAD),
      .ACTIVE_COLS(ACTIVE_COLS), .ACTIVE_ROWS(ACTIVE_ROWS),
      .TOP_DARK(TOP_DARK), .BOT_DARK(BOT_DARK), .COLOR(COLOR),
      .LW(LW), .CW(CW)
   ) u_cls (
      .line_i(line_q), .col_i(col_q), .region_o(rg), .cfa_o(cf)
   );

   assign line_ok = (line_q < L_FRAME);

   ccdtag_darkacc #(
      .DW(DW), .DUMMY_COLS(DUMMY_COLS), .DARK_COLS(DARK_COLS),
      .AVG_SHIFT(AVG_SHIFT), .CW(CW), .ACC_W(ACC_W), .AVG_W(AVG_W)
   ) u_dark (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sof_i || sol_i),
      .pix_vld_i(pix_vld_i), .line_ok_i(line_ok), .col_i(col_q),
      .data_i(pix_data_i), .avg_o(dark_avg_o), .avg_vld_o(dark_avg_vld_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tag_vld_o  <= 1'b0;
         region_o   <= '0;
         cfa_o      <= '0;
         pix_data_o <= '0;
      end else begin
         tag_vld_o <= pix_vld_i;
         if (pix_vld_i) begin
            region_o   <= rg;
            cfa_o      <= cf;
            pix_data_o <= pix_data_i;
         end
      end
   end

   a_r8_avg_on_dark_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dark_avg_vld_o |-> tag_vld_o && (region_o == RG_DARK));
   a_r7_cfa_idle_off_image: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tag_vld_o && (region_o != RG_BUFFER) && (region_o != RG_ACTIVE)) |-> (cfa_o == 2'd0));
   a_r9_err_not_with_avg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({dark_avg_vld_o, line_err_o}));
endmodule

// File: tb/ccd_region_tagger_tb.sv
module ccd_region_tagger_tb;
   localparam int DW = 12, LL = 34, FL = 20, DUM = 4, DRK = 8, BUF = 4, BLU = 2;
   localparam int AC = 10, AR = 6, TOP = 3, BOT = 2, SH = 3;
   localparam int AVG_W = DW + $clog2(DRK + 1) - SH;

   logic clk = 1'b0, rst_n = 1'b0, sof = 1'b0, sol = 1'b0, vld = 1'b0;
   logic [DW-1:0] din = '0;
   logic tag_vld, avg_vld, lerr;
   logic [2:0] region;
   logic [1:0] cfa;
   logic [DW-1:0] dout;
   logic [AVG_W-1:0] avg;

   int checks = 0, errors = 0;
   int o_vld, o_rg, o_cfa, o_data, o_avg, o_avgv;

   always #10 clk = ~clk;

   ccd_region_tagger #(
      .DW(DW), .LINE_LEN(LL), .FRAME_LINES(FL), .DUMMY_COLS(DUM), .DARK_COLS(DRK),
      .BUF_BAND(BUF), .BLUE_LEAD(BLU), .ACTIVE_COLS(AC), .ACTIVE_ROWS(AR),
      .TOP_DARK(TOP), .BOT_DARK(BOT), .AVG_SHIFT(SH), .COLOR(1'b1)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .sol_i(sol), .pix_vld_i(vld),
      .pix_data_i(din), .tag_vld_o(tag_vld), .region_o(region), .cfa_o(cfa),
      .pix_data_o(dout), .dark_avg_o(avg), .dark_avg_vld_o(avg_vld), .line_err_o(lerr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_region(input int l, input int c);
      if (l >= FL || c >= LL) return 4;
      if (c < DUM) return 0;
      if (l < TOP || l >= TOP + 2 * BUF + AR) return 1;
      if (c < DUM + DRK) return 1;
      if (c < DUM + DRK + BUF) return 2;
      if (c < DUM + DRK + BUF + AC)
         return (l >= TOP + BUF && l < TOP + BUF + AR) ? 3 : 2;
      if (c < DUM + DRK + 2 * BUF + AC) return 2;
      return 1;
   endfunction

   function automatic int exp_cfa(input int l, input int c);
      int r = exp_region(l, c);
      if (r != 2 && r != 3) return 0;
      if (c < DUM + DRK + BLU) return 3;
      return (((l - TOP) & 1) << 1) | ((c - (DUM + DRK + BLU)) & 1);
   endfunction

   function automatic int pat(input int l, input int c);
      return (l * 37 + c * 101) & ((1 << DW) - 1);
   endfunction

   function automatic string reg_tag(input int l, input int c);
      int r = exp_region(l, c);
      if (r == 0) return "R2";
      if (r == 4) return "R6";
      if (r == 1) return (l < TOP || l >= TOP + 2 * BUF + AR) ? "R4" : "R3";
      return "R5";
   endfunction

   task automatic px(input int d);
      @(negedge clk);
      vld = 1'b1;
      din = DW'(d);
      @(negedge clk);
      vld = 1'b0;
      o_vld = int'(tag_vld); o_rg = int'(region); o_cfa = int'(cfa);
      o_data = int'(dout); o_avg = int'(avg); o_avgv = int'(avg_vld);
   endtask

   task automatic strobe_sof();
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
   endtask

   task automatic strobe_sol(input bit exp_err);
      @(negedge clk); sol = 1'b1;
      @(negedge clk); sol = 0;
      chk(lerr == exp_err, "R9", int'(lerr), int'(exp_err));
   endtask

   // Scan columns 0..upto-1 of line l, checking tag, colour, data and dark value.
   task automatic scan_line(input int l, input int upto);
      int sum = 0;
      for (int c = 0; c < upto; c++) begin
         int d = (c >= DUM && c < DUM + DRK) ? pat(l, c) : (1 << DW) - 1;
         if (c >= DUM && c < DUM + DRK) sum += d;
         px(d);
         chk(o_vld == 1 && o_data == d, "R11", o_data, d);
         chk(o_rg == exp_region(l, c), reg_tag(l, c), o_rg, exp_region(l, c));
         chk(o_cfa == exp_cfa(l, c), "R7", o_cfa, exp_cfa(l, c));
         if (c == DUM + DRK - 1) begin
            chk(o_avgv == 1, "R8", o_avgv, 1);
            chk(o_avg == (sum >> SH), "R8", o_avg, sum >> SH);
         end else begin
            chk(o_avgv == 0, "R8", o_avgv, 0);
         end
      end
   endtask

   task automatic t_reset();
      chk(tag_vld == 0 && avg_vld == 0 && lerr == 0, "R1", int'({tag_vld, avg_vld, lerr}), 0);
      @(negedge clk); rst_n = 1'b1;
      chk(tag_vld == 0 && avg_vld == 0 && lerr == 0, "R1", int'({tag_vld, avg_vld, lerr}), 0);
      px(5);
      chk(o_rg == 4, "R1", o_rg, 4);
      strobe_sol(1'b0);
   endtask

   task automatic t_full_frame();
      strobe_sof();
      for (int l = 0; l < FL; l++) begin
         if (l > 0) strobe_sol(1'b0);
         scan_line(l, LL);
      end
      strobe_sol(1'b0);
      for (int k = 0; k < 3; k++) begin
         px(7);
         chk(o_rg == 4, "R6", o_rg, 4);
         chk(o_cfa == 0, "R7", o_cfa, 0);
      end
      strobe_sol(1'b0);
   endtask

   task automatic t_line_overrun();
      strobe_sof();
      scan_line(0, LL);
      for (int k = 0; k < 3; k++) begin
         px(9);
         chk(o_rg == 4, "R6", o_rg, 4);
      end
      strobe_sol(1'b0);
   endtask

   task automatic t_short_line();
      strobe_sof();
      for (int k = 0; k < 5; k++) px(1);
      strobe_sol(1'b1);
      @(negedge clk);
      chk(lerr == 0, "R9", int'(lerr), 0);
      scan_line(1, DUM + 2);
      chk(o_rg == 1, "R10", o_rg, 1);
   endtask

   task automatic t_restart();
      strobe_sof();
      for (int l = 0; l < TOP + BUF; l++) begin
         scan_line(l, LL);
         strobe_sol(1'b0);
      end
      scan_line(TOP + BUF, DUM + DRK + BUF + 4);
      chk(o_rg == 3, "R5", o_rg, 3);
      strobe_sof();
      scan_line(0, DUM + DRK + BUF + 6);
      chk(o_rg == 1, "R10", o_rg, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_full_frame();
      t_line_overrun();
      t_short_line();
      t_restart();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule